// File: doc/BRIEF.md
# Keyed Watchdog Timer with Power-of-Two Prescaler

This block is a watchdog that runs from a slow free-running clock. It has two cascaded power-of-two dividers and an 8-bit down-counter. Software programs the block through a small register port in the bus clock domain. It arms the counter by setting a self-clearing reload bit. It then keeps the counter from expiring by writing a fixed key byte to a service register. When the count runs out, the block raises a one-cycle reset request in the slow domain. It then stops and waits for the next reload.

Requests that cross from the bus clock to the slow clock use toggle synchronizers, so no request is lost whatever the phase of the two clocks. A sticky cause flag records that a watchdog reset happened. A system reset does not clear it; only power-on reset or a write of one clears it. An optional early-touch check treats a key written too soon after the last restart as a fault. The live count can be read at any time. Because it is sampled across clock domains, software repeats the read until two reads agree.

Top module: `wdt_top`

## Requirements
- R1: After reset, every readable register returns 0, the count reads 0, the timer is idle and `wd_rst_req` is low.
- R2: Writing a 1 to bit 0 of the control register (address 0) loads the count from the reload register (address 4), clears both dividers and starts the timer. Bit 0 reads 1 from the write until the slow domain has taken the load, then reads 0.
- R3: Let p be the first exponent (address 2, bits 3:0) and w the second exponent (address 3, bits 3:0). Let S be 1 when config bit 1 (address 1) selects the divided tick, else 0. Once started with reload value N, the timer expires after N * (S ? 2^p : 1) * 2^w slow-clock cycles.
- R4: On expiry, `wd_rst_req` is high for exactly one slow-clock cycle. After that the timer is idle and the count stays frozen until the next reload.
- R5: Writing 0x5C to the service register (address 5) while config bit 0 is 1 and the timer runs restarts the count from the reload value.
- R6: A service write of any other value, or any service write while config bit 0 is 0, leaves the count running down undisturbed.
- R7: With control bit 1 at 0, a valid key that arrives while the count exceeds half the reload value causes an immediate reset request. With control bit 1 at 1, such a key only restarts the count. A key at or below half never causes a reset request.
- R8: Control bit 3 becomes 1 when a reset request is issued. It survives `rst`, ignores written zeros, and is cleared by writing 1 to it or by `por`.
- R9: Control bit 2 is read-only and reads 1 while the timer runs and 0 once it has expired or before it is started.
- R10: Address 6 returns the live count; writes there have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bus_clk | input | 1 | Register port clock |
| slow_clk | input | 1 | Slow timebase clock |
| por | input | 1 | Power-on reset, synchronous, clears everything |
| rst | input | 1 | System reset, synchronous, keeps the cause flag |
| bus_addr | input | 3 | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data for the previous address |
| wd_rst_req | output | 1 | Reset request pulse, slow clock domain |

## Verification
The hardest state to reach is a key that lands on the right side of the half-reload threshold after the crossing delay. The bench waits a measured number of slow cycles after the load completes, so the key arrives well above half in one case and well below it in another. Expiry timing is swept across every combination of a small set of exponents, source selections and reload values. The measured delay from the reload write to the pulse is checked against the arithmetic product plus a fixed crossing window. The cause flag is driven through a system reset, a zero write and a one write in turn.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_CFG  = 3'd1;
  localparam logic [ADDR_W-1:0] A_PRE  = 3'd2;
  localparam logic [ADDR_W-1:0] A_WDP  = 3'd3;
  localparam logic [ADDR_W-1:0] A_RLD  = 3'd4;
  localparam logic [ADDR_W-1:0] A_SVC  = 3'd5;
  localparam logic [ADDR_W-1:0] A_CNT  = 3'd6;
  localparam logic [7:0] SVC_KEY = 8'h5C;
  // control register bits
  localparam int C_LOAD = 0;
  localparam int C_NOEARLY = 1;
  localparam int C_FLAG = 3;
endpackage

// File: rtl/wdt_tsync.sv
module wdt_tsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;
  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[STAGES-2:0], d};
  end
  assign q = sh[STAGES-1];
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 8,
  parameter int EXP_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              por,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              ack_lvl,
  input  logic              run_lvl,
  input  logic              bite_lvl,
  input  logic [CNT_W-1:0]  cnt_live,
  output logic              rl_tgl,
  output logic              key_tgl,
  output logic              no_early,
  output logic              src_pre,
  output logic [EXP_W-1:0]  pre_exp,
  output logic [EXP_W-1:0]  wdp_exp,
  output logic [CNT_W-1:0]  rld_val
);
  logic key_en;
  logic flag_q;
  logic bite_prev;
  logic pend;

  assign pend = rl_tgl ^ ack_lvl;

  always_ff @(posedge clk) begin
    if (rst) begin
      rl_tgl   <= 1'b0;
      key_tgl  <= 1'b0;
      no_early <= 1'b0;
      key_en   <= 1'b0;
      src_pre  <= 1'b0;
      pre_exp  <= '0;
      wdp_exp  <= '0;
      rld_val  <= '0;
    end else if (we) begin
      case (addr)
        A_CTRL: begin
          no_early <= wdata[C_NOEARLY];
          if (wdata[C_LOAD] && !pend) rl_tgl <= ~rl_tgl;
        end
        A_CFG: begin
          key_en  <= wdata[0];
          src_pre <= wdata[1];
        end
        A_PRE: pre_exp <= wdata[EXP_W-1:0];
        A_WDP: wdp_exp <= wdata[EXP_W-1:0];
        A_RLD: rld_val <= wdata[CNT_W-1:0];
        A_SVC: if (key_en && wdata == SVC_KEY) key_tgl <= ~key_tgl;
        default: ;
      endcase
    end
  end

  // cause flag lives on the power-on reset only
  always_ff @(posedge clk) begin
    if (por) begin
      flag_q    <= 1'b0;
      bite_prev <= 1'b0;
    end else begin
      bite_prev <= bite_lvl;
      if (bite_lvl ^ bite_prev) flag_q <= 1'b1;
      else if (we && addr == A_CTRL && wdata[C_FLAG]) flag_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else begin
      case (addr)
        A_CTRL:  rdata <= DATA_W'({flag_q, run_lvl, no_early, pend});
        A_CFG:   rdata <= DATA_W'({src_pre, key_en});
        A_PRE:   rdata <= DATA_W'(pre_exp);
        A_WDP:   rdata <= DATA_W'(wdp_exp);
        A_RLD:   rdata <= DATA_W'(rld_val);
        A_CNT:   rdata <= DATA_W'(cnt_live);
        default: rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/wdt_core.sv
module wdt_core #(
  parameter int CNT_W = 8,
  parameter int EXP_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             por,
  input  logic             rl_lvl,
  input  logic             key_lvl,
  input  logic [CNT_W-1:0] rld_val,
  input  logic [EXP_W-1:0] pre_exp,
  input  logic [EXP_W-1:0] wdp_exp,
  input  logic             src_pre,
  input  logic             no_early,
  output logic [CNT_W-1:0] count,
  output logic             running,
  output logic             bite,
  output logic             bite_tgl,
  output logic             ack
);
  localparam int DIV_W = (1 << EXP_W) - 1;

  logic             rl_prev, key_prev;
  logic             rl_pulse, key_pulse;
  logic [DIV_W-1:0] pre_cnt, wdp_cnt;
  logic [DIV_W-1:0] pre_lim, wdp_lim;
  logic             pre_tick, src_tick, wd_tick;
  logic             early, bite_set;

  assign rl_pulse  = rl_lvl ^ rl_prev;
  assign key_pulse = key_lvl ^ key_prev;
  assign ack       = rl_prev;

  assign pre_lim  = DIV_W'((32'd1 << pre_exp) - 32'd1);
  assign wdp_lim  = DIV_W'((32'd1 << wdp_exp) - 32'd1);
  assign pre_tick = (pre_cnt == pre_lim);
  assign src_tick = src_pre ? pre_tick : 1'b1;
  assign wd_tick  = src_tick && (wdp_cnt == wdp_lim);

  always_comb begin
    early    = key_pulse && !no_early && (count > (rld_val >> 1));
    bite_set = !rst && !rl_pulse && running &&
               (key_pulse ? early : (wd_tick && count <= CNT_W'(1)));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rl_prev  <= 1'b0;
      key_prev <= 1'b0;
      count    <= '0;
      running  <= 1'b0;
      bite     <= 1'b0;
      pre_cnt  <= '0;
      wdp_cnt  <= '0;
    end else begin
      rl_prev  <= rl_lvl;
      key_prev <= key_lvl;
      bite     <= bite_set;
      if (rl_pulse) begin
        count   <= rld_val;
        running <= 1'b1;
        pre_cnt <= '0;
        wdp_cnt <= '0;
      end else if (running) begin
        if (bite_set) begin
          running <= 1'b0;
          if (!key_pulse) count <= '0;
        end else if (key_pulse) begin
          count   <= rld_val;
          pre_cnt <= '0;
          wdp_cnt <= '0;
        end else begin
          pre_cnt <= pre_tick ? '0 : pre_cnt + 1'b1;
          if (src_tick) wdp_cnt <= wd_tick ? '0 : wdp_cnt + 1'b1;
          if (wd_tick) count <= count - 1'b1;
        end
      end
    end
  end

  // event toggle for the bus-side cause flag, cleared only at power-on
  always_ff @(posedge clk) begin
    if (por)           bite_tgl <= 1'b0;
    else if (bite_set) bite_tgl <= ~bite_tgl;
  end
endmodule

// File: rtl/wdt_top.sv
module wdt_top
  import wdt_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int EXP_W  = 4,
  parameter int SYNC_N = 2
) (
  input  logic       bus_clk,
  input  logic       slow_clk,
  input  logic       por,
  input  logic       rst,
  input  logic [2:0] bus_addr,
  input  logic       bus_we,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       wd_rst_req
);
  logic             rst_any;
  logic             rl_tgl, key_tgl, no_early, src_pre;
  logic [EXP_W-1:0] pre_exp, wdp_exp;
  logic [CNT_W-1:0] rld_val, s_count;
  logic             rl_lvl, key_lvl, ack_s, ack_b, run_b, s_running;
  logic             bite_tgl, bite_b;

  assign rst_any = rst | por;

  wdt_regs #(.DATA_W(8), .CNT_W(CNT_W), .EXP_W(EXP_W)) u_regs (
    .clk(bus_clk), .rst(rst_any), .por(por),
    .addr(bus_addr), .we(bus_we), .wdata(bus_wdata), .rdata(bus_rdata),
    .ack_lvl(ack_b), .run_lvl(run_b), .bite_lvl(bite_b), .cnt_live(s_count),
    .rl_tgl(rl_tgl), .key_tgl(key_tgl), .no_early(no_early), .src_pre(src_pre),
    .pre_exp(pre_exp), .wdp_exp(wdp_exp), .rld_val(rld_val)
  );

  wdt_tsync #(.STAGES(SYNC_N)) u_s_rl  (.clk(slow_clk), .rst(rst_any), .d(rl_tgl),  .q(rl_lvl));
  wdt_tsync #(.STAGES(SYNC_N)) u_s_key (.clk(slow_clk), .rst(rst_any), .d(key_tgl), .q(key_lvl));
  wdt_tsync #(.STAGES(SYNC_N)) u_b_ack (.clk(bus_clk),  .rst(rst_any), .d(ack_s),   .q(ack_b));
  wdt_tsync #(.STAGES(SYNC_N)) u_b_run (.clk(bus_clk),  .rst(rst_any), .d(s_running), .q(run_b));
  wdt_tsync #(.STAGES(SYNC_N)) u_b_bit (.clk(bus_clk),  .rst(por),     .d(bite_tgl),  .q(bite_b));

  wdt_core #(.CNT_W(CNT_W), .EXP_W(EXP_W)) u_core (
    .clk(slow_clk), .rst(rst_any), .por(por),
    .rl_lvl(rl_lvl), .key_lvl(key_lvl), .rld_val(rld_val),
    .pre_exp(pre_exp), .wdp_exp(wdp_exp), .src_pre(src_pre), .no_early(no_early),
    .count(s_count), .running(s_running), .bite(wd_rst_req),
    .bite_tgl(bite_tgl), .ack(ack_s)
  );
endmodule

// File: rtl/wdt_chk.sv
module wdt_chk #(
  parameter int CNT_W = 8
) (
  input logic             slow_clk,
  input logic             bus_clk,
  input logic             rst_s,
  input logic             por,
  input logic             bite,
  input logic             s_running,
  input logic [CNT_W-1:0] count,
  input logic             rl_pulse,
  input logic             key_pulse,
  input logic             flag,
  input logic             pend,
  input logic             we,
  input logic [2:0]       addr,
  input logic [7:0]       wdata
);
  // R4
  bite_single_chk: assert property (@(posedge slow_clk) disable iff (rst_s)
    bite |=> !bite);
  // R4
  bite_stop_chk: assert property (@(posedge slow_clk) disable iff (rst_s)
    bite |-> !s_running);
  // R4
  frozen_chk: assert property (@(posedge slow_clk) disable iff (rst_s)
    (!s_running && !rl_pulse) |=> $stable(count));
  // R3
  no_rise_chk: assert property (@(posedge slow_clk) disable iff (rst_s)
    (s_running && !rl_pulse && !key_pulse) |=> (count <= $past(count)));
  // R2
  start_chk: assert property (@(posedge slow_clk) disable iff (rst_s)
    rl_pulse |=> s_running);
  // R2
  pend_chk: assert property (@(posedge bus_clk) disable iff (rst_s)
    (we && addr == 3'd0 && wdata[0] && !pend) |=> pend);
  // R8
  flag_hold_chk: assert property (@(posedge bus_clk) disable iff (por)
    (flag && !(we && addr == 3'd0 && wdata[3])) |=> flag);
endmodule

bind wdt_top wdt_chk #(.CNT_W(CNT_W)) u_chk (
  .slow_clk(slow_clk), .bus_clk(bus_clk), .rst_s(rst_any), .por(por),
  .bite(wd_rst_req), .s_running(s_running), .count(s_count),
  .rl_pulse(u_core.rl_pulse), .key_pulse(u_core.key_pulse),
  .flag(u_regs.flag_q), .pend(u_regs.pend),
  .we(bus_we), .addr(bus_addr), .wdata(bus_wdata)
);

// File: tb/sim_wdt_top.sv
module sim_wdt_top;
  localparam int CLK_PERIOD  = 10;
  localparam int SLOW_PERIOD = 46;

  logic       bus_clk = 0, slow_clk = 0, por = 1, rst = 1;
  logic [2:0] addr = 0;
  logic       we = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic       wd_rst_req;

  int total = 0, bad = 0;
  int scnt = 0, bite_cnt = 0, bite_time = 0, run_len = 0, max_run = 0;

  wdt_top u0 (.bus_clk(bus_clk), .slow_clk(slow_clk), .por(por), .rst(rst),
    .bus_addr(addr), .bus_we(we), .bus_wdata(wdata), .bus_rdata(rdata),
    .wd_rst_req(wd_rst_req));

  always #(CLK_PERIOD/2) bus_clk = ~bus_clk;
  always #(SLOW_PERIOD/2) slow_clk = ~slow_clk;
  always @(posedge slow_clk) scnt++;
  always @(negedge slow_clk) begin
    if (wd_rst_req) begin
      if (run_len == 0) begin bite_cnt++; bite_time = scnt; end
      run_len++;
      if (run_len > max_run) max_run = run_len;
    end else run_len = 0;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge bus_clk); addr = a; wdata = d; we = 1;
    @(negedge bus_clk); we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge bus_clk); addr = a; we = 0;
    @(negedge bus_clk); d = rdata;
  endtask

  task automatic rd_cnt(output int c);
    logic [7:0] x, y;
    do begin rd(3'd6, x); rd(3'd6, y); end while (x != y);
    c = x;
  endtask

  task automatic ws(input int n);
    repeat (n) @(negedge slow_clk);
  endtask

  task automatic wait_load();
    logic [7:0] v;
    for (int i = 0; i < 200; i++) begin
      rd(3'd0, v);
      if (!v[0]) break;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    total++; bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int c1, c2, b0, t0, e;
    ws(6); por = 0; rst = 0; ws(2);

    // R1 reset state
    rd(3'd0, v); chk(v == 0, "R1 ctrl", v, 0);
    rd(3'd6, v); chk(v == 0, "R1 count", v, 0);
    chk(wd_rst_req == 0, "R1 req", wd_rst_req, 0);

    // R2 reload handshake, R9 running, R10 live count
    wr(3'd4, 8'd200); wr(3'd1, 8'h01); wr(3'd2, 0); wr(3'd3, 0);
    wr(3'd0, 8'h03);
    rd(3'd0, v); chk(v[0] == 1, "R2 pending", v[0], 1);
    wait_load();
    rd(3'd0, v); chk(v[0] == 0, "R2 cleared", v[0], 0);
    ws(4);
    rd(3'd0, v); chk(v[2] == 1, "R9 running", v[2], 1);
    rd_cnt(c1); chk(c1 > 150 && c1 <= 200, "R10 live count", c1, 200);
    wr(3'd6, 8'd7); rd_cnt(c2); chk(c2 <= c1 && c2 > 140, "R10 write ignored", c2, c1);

    // R6 wrong key value
    ws(60); rd_cnt(c1); wr(3'd5, 8'h5D); ws(8); rd_cnt(c2);
    chk(c2 < c1, "R6 wrong key", c2, c1);
    // R6 key disabled
    wr(3'd1, 8'h00); rd_cnt(c1); wr(3'd5, 8'h5C); ws(8); rd_cnt(c2);
    chk(c2 < c1, "R6 key disabled", c2, c1);
    // R5 valid key; count above half so R7 early-disabled path also applies
    wr(3'd1, 8'h01); b0 = bite_cnt; rd_cnt(c1); wr(3'd5, 8'h5C); ws(8); rd_cnt(c2);
    chk(c2 >= 185 && c2 <= 200, "R5 key reload", c2, 200);
    chk(bite_cnt == b0, "R7 early touch disabled", bite_cnt, b0);

    // R7 early touch enabled -> immediate request
    wr(3'd4, 8'd100); wr(3'd0, 8'h01); wait_load();
    b0 = bite_cnt; wr(3'd5, 8'h5C); ws(10);
    chk(bite_cnt == b0 + 1, "R7 early key bites", bite_cnt, b0 + 1);
    ws(4); rd(3'd0, v);
    chk(v[3] == 1, "R8 flag set", v[3], 1);
    chk(v[2] == 0, "R9 stopped", v[2], 0);
    // R4 frozen after expiry
    rd_cnt(c1); ws(50); rd_cnt(c2);
    chk(c1 == c2, "R4 frozen", c2, c1);
    chk(bite_cnt == b0 + 1, "R4 no repeat", bite_cnt, b0 + 1);

    // R7 late key with early touch enabled only reloads
    wr(3'd4, 8'd20); wr(3'd0, 8'h01); wait_load();
    ws(10); b0 = bite_cnt; wr(3'd5, 8'h5C); ws(6); rd_cnt(c2);
    chk(c2 >= 12 && c2 <= 20, "R7 late key reload", c2, 20);
    chk(bite_cnt == b0, "R7 late key no bite", bite_cnt, b0);
    ws(40);
    chk(bite_cnt == b0 + 1, "R3 expiry after late key", bite_cnt, b0 + 1);
    chk(max_run == 1, "R4 pulse width", max_run, 1);

    // R8 flag survives system reset, W1C only
    @(negedge bus_clk); rst = 1; ws(4); @(negedge bus_clk); rst = 0; ws(4);
    rd(3'd0, v); chk(v == 8'h08, "R8 survives rst", v, 8);
    wr(3'd0, 8'h00); rd(3'd0, v); chk(v[3] == 1, "R8 zero write", v[3], 1);
    wr(3'd0, 8'h08); rd(3'd0, v); chk(v[3] == 0, "R8 w1c", v[3], 0);

    // R3 timing sweep
    for (int p = 0; p < 4; p++)
      for (int w = 0; w < 2; w++)
        for (int s = 0; s < 2; s++)
          for (int n = 3; n <= 5; n += 2) begin
            wr(3'd2, 8'(p)); wr(3'd3, 8'(w)); wr(3'd1, 8'(s << 1));
            wr(3'd4, 8'(n));
            e = n * (s ? (1 << p) : 1) * (1 << w);
            b0 = bite_cnt;
            wr(3'd0, 8'h03); t0 = scnt;
            for (int k = 0; k < e + 40 && bite_cnt == b0; k++) ws(1);
            chk(bite_cnt == b0 + 1 && bite_time - t0 >= e + 2 && bite_time - t0 <= e + 6,
                "R3 expiry delay", bite_time - t0, e + 3);
            ws(3);
          end
    chk(max_run == 1, "R4 pulse width sweep", max_run, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule